// File: doc/BRIEF.md
# Shift Unit with Carry and Extend Flags

This block shifts a 32-bit operand left logically, right logically or right arithmetically. The shift amount comes in on a wider count bus, and only its value modulo 64 is used. The shifted value is produced combinationally in the same cycle. A set of five condition flags (negative, zero, overflow, carry, extend) is captured into a register on the clock edge at which the valid strobe is high.

The carry rules depend on the shift amount. A zero amount passes the operand through unchanged and reuses the carry flag supplied by the surrounding datapath. Amounts from 1 to 31 take the carry from the last bit shifted out. Logical shifts treat an amount of exactly 32 differently from amounts above 32. Arithmetic right shifts of 32 or more saturate to the sign. The extend flag always copies the new carry, and the overflow flag is always cleared. The block sits beside an integer datapath: the instruction decoder supplies the kind and the count, and the flag register feeds the condition-code logic.

The control is a single decision on the shift kind (`unique case`) with no sequential state apart from the flag register. The flag register has two conditions. It is loaded when the strobe is high and holds its value when the strobe is low. Reset clears it.

Top module: `shift_flag_unit`

## Requirements
- R1: Only `count_i` modulo 64 (its low six bits) sets the shift amount, so a count of 68 acts as 4 and a count of 96 acts as 32.
- R2: An amount of 0 gives `result_o == data_i`, and on the strobe edge C and X take `carry_i`.
- R3: A left logical shift by n in 1..31 gives `data_i << n` with zero fill, and C is `data_i[32-n]`.
- R4: A right shift by n in 1..31 takes C from `data_i[n-1]`. The logical form fills the top with zeros and the arithmetic form fills it with `data_i[31]`.
- R5: A logical shift by exactly 32 gives a zero result. C is `data_i[0]` for a left shift and `data_i[31]` for a right shift.
- R6: A logical shift by 33..63 gives a zero result with C cleared.
- R7: An arithmetic right shift by 32..63 gives `data_i[31]` copied into all 32 bits, and C equals `data_i[31]`.
- R8: After every flag update, X equals the new C.
- R9: On a flag update, N is bit 31 of the result, Z is set exactly when the result is zero, and V is cleared.
- R10: Reset clears all five flags. The flags change only at a clock edge where `valid_i` is high and hold otherwise.
- R11: Kind encoding on `kind_i`: 2'b00 is left logical, 2'b01 is right logical, 2'b10 is right arithmetic, and 2'b11 also performs a right arithmetic shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| valid_i | input | 1 | Loads the flag register at the next rising edge |
| kind_i | input | 2 | Shift kind, encoded as in R11 |
| count_i | input | CNT_W (8) | Shift count, used modulo 64 |
| data_i | input | DATA_W (32) | Operand |
| carry_i | input | 1 | Current carry flag, used when the amount is zero |
| result_o | output | DATA_W (32) | Shifted value, combinational |
| flag_n_o | output | 1 | Registered negative flag |
| flag_z_o | output | 1 | Registered zero flag |
| flag_v_o | output | 1 | Registered overflow flag |
| flag_c_o | output | 1 | Registered carry flag |
| flag_x_o | output | 1 | Registered extend flag |

## Verification
`result_o` has no register on its path, so it is valid in the same cycle the inputs are driven. The bench reads it one time unit after driving at a falling edge. The five flags pass through one register, so they are due after the first rising edge with `valid_i` high, and the bench reads them at the following falling edge. For the hold and reset checks, the bench waits several edges with the strobe low, or drops reset between edges, and then reads the flags at a falling edge.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SK_LSL     = 2'b00,
        SK_LSR     = 2'b01,
        SK_ASR     = 2'b10,
        SK_ASR_ALT = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
        logic x;
    } flags_t;

endpackage

// File: rtl/shf_core.sv
// Combinational shifter: result and carry-out for one shift operation.
module shf_core #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input  logic [DATA_W-1:0]       data_i,
    input  shf_pkg::shift_kind_e    kind_i,
    input  logic [AMT_W-1:0]        amt_i,
    input  logic                    carry_i,
    output logic [DATA_W-1:0]       result_o,
    output logic                    carry_o
);
    // One spare bit beside the operand catches the last bit shifted out.
    logic        [DATA_W:0] wide_l;
    logic        [DATA_W:0] wide_r;
    logic signed [DATA_W:0] wide_a;

    always_comb begin
        wide_l = {1'b0, data_i} << amt_i;
        wide_r = {data_i, 1'b0} >> amt_i;
        wide_a = $signed({data_i, 1'b0}) >>> amt_i;
    end

    always_comb begin
        result_o = data_i;
        carry_o  = carry_i;
        if (amt_i != '0) begin
            unique case (kind_i)
                shf_pkg::SK_LSL: begin
                    result_o = wide_l[DATA_W-1:0];
                    carry_o  = wide_l[DATA_W];
                end
                shf_pkg::SK_LSR: begin
                    result_o = wide_r[DATA_W:1];
                    carry_o  = wide_r[0];
                end
                shf_pkg::SK_ASR, shf_pkg::SK_ASR_ALT: begin
                    result_o = wide_a[DATA_W:1];
                    carry_o  = wide_a[0];
                end
            endcase
        end
    end
endmodule

// File: rtl/shf_flag_reg.sv
// Condition flag register, loaded on the valid strobe.
module shf_flag_reg #(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic [DATA_W-1:0]    result_i,
    input  logic                 carry_i,
    output shf_pkg::flags_t      flags_o
);
    shf_pkg::flags_t flags_d;

    always_comb begin
        flags_d.n = result_i[DATA_W-1];
        flags_d.z = (result_i == '0);
        flags_d.v = 1'b0;
        flags_d.c = carry_i;
        flags_d.x = carry_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else if (valid_i) begin
            flags_o <= flags_d;
        end
    end
endmodule

// File: rtl/shift_flag_unit.sv
// Top: 32-bit shift unit with registered N/Z/V/C/X flags.
module shift_flag_unit #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic [1:0]          kind_i,
    input  logic [CNT_W-1:0]    count_i,
    input  logic [DATA_W-1:0]   data_i,
    input  logic                carry_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                flag_n_o,
    output logic                flag_z_o,
    output logic                flag_v_o,
    output logic                flag_c_o,
    output logic                flag_x_o
);
    // The amount is taken modulo 2*DATA_W: keep the low AMT_W bits.
    localparam int AMT_W = $clog2(DATA_W) + 1;

    logic [AMT_W-1:0]     amt;
    logic                 carry_new;
    shf_pkg::shift_kind_e kind;
    shf_pkg::flags_t      flags_q;

    assign amt  = count_i[AMT_W-1:0];
    assign kind = shf_pkg::shift_kind_e'(kind_i);

    generate
        if (CNT_W > AMT_W) begin : g_cnt_hi
            logic unused_cnt_hi;
            assign unused_cnt_hi = ^count_i[CNT_W-1:AMT_W];
        end
    endgenerate

    shf_core #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) core_i (
        .data_i   (data_i),
        .kind_i   (kind),
        .amt_i    (amt),
        .carry_i  (carry_i),
        .result_o (result_o),
        .carry_o  (carry_new)
    );

    shf_flag_reg #(
        .DATA_W (DATA_W)
    ) flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_i),
        .result_i (result_o),
        .carry_i  (carry_new),
        .flags_o  (flags_q)
    );

    assign flag_n_o = flags_q.n;
    assign flag_z_o = flags_q.z;
    assign flag_v_o = flags_q.v;
    assign flag_c_o = flags_q.c;
    assign flag_x_o = flags_q.x;
endmodule

// File: rtl/shf_flag_chk.sv
// Property checker bound to shift_flag_unit.
module shf_flag_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid_i,
    input logic [1:0]          kind_i,
    input logic [CNT_W-1:0]    count_i,
    input logic [DATA_W-1:0]   data_i,
    input logic                carry_i,
    input logic [DATA_W-1:0]   result_o,
    input logic                flag_n_o,
    input logic                flag_z_o,
    input logic                flag_v_o,
    input logic                flag_c_o,
    input logic                flag_x_o
);
    localparam int MOD = 2 * DATA_W;

    int amt;
    always_comb amt = int'(count_i % CNT_W'(MOD));

    // R2
    zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amt == 0) |-> (result_o == data_i));

    // R2
    zero_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && amt == 0) |=> (flag_c_o == $past(carry_i)));

    // R6
    far_logical_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !kind_i[1] && amt > DATA_W) |=> (!flag_c_o && flag_z_o));

    // R7
    far_arith_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i[1] && amt >= DATA_W) |-> (result_o == {DATA_W{data_i[DATA_W-1]}}));

    // R5 R8
    exact_logical_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !kind_i[1] && amt == DATA_W)
        |=> (flag_x_o == $past(kind_i[0] ? data_i[DATA_W-1] : data_i[0])));

    // R9
    nzv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> ((flag_z_o == ($past(result_o) == '0))
                     && (flag_n_o == $past(result_o[DATA_W-1])) && !flag_v_o));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable({flag_n_o, flag_z_o, flag_v_o, flag_c_o, flag_x_o}));
endmodule

bind shift_flag_unit shf_flag_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .kind_i   (kind_i),
    .count_i  (count_i),
    .data_i   (data_i),
    .carry_i  (carry_i),
    .result_o (result_o),
    .flag_n_o (flag_n_o),
    .flag_z_o (flag_z_o),
    .flag_v_o (flag_v_o),
    .flag_c_o (flag_c_o),
    .flag_x_o (flag_x_o)
);

// File: tb/shift_flag_unit_tb_top.sv
module shift_flag_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    typedef struct packed {
        logic [7:0]  req;
        logic [1:0]  kind;
        logic [7:0]  cnt;
        logic [31:0] data;
        logic        cin;
        logic [31:0] res;
        logic        c;
    } vec_t;

    // kind: 00 left logical, 01 right logical, 10/11 right arithmetic (R11)
    localparam vec_t VECS [NVEC] = '{
        '{8'd2,  2'b00, 8'd0,   32'h8000_0001, 1'b1, 32'h8000_0001, 1'b1}, // R2
        '{8'd2,  2'b00, 8'd0,   32'h1234_5678, 1'b0, 32'h1234_5678, 1'b0}, // R2
        '{8'd3,  2'b00, 8'd4,   32'hF000_000F, 1'b0, 32'h0000_00F0, 1'b1}, // R3
        '{8'd3,  2'b00, 8'd1,   32'h4000_0000, 1'b1, 32'h8000_0000, 1'b0}, // R3
        '{8'd3,  2'b00, 8'd31,  32'h0000_0003, 1'b0, 32'h8000_0000, 1'b1}, // R3
        '{8'd5,  2'b00, 8'd32,  32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1}, // R5
        '{8'd6,  2'b00, 8'd33,  32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0}, // R6
        '{8'd4,  2'b01, 8'd1,   32'h0000_0003, 1'b0, 32'h0000_0001, 1'b1}, // R4
        '{8'd4,  2'b01, 8'd8,   32'h8000_0080, 1'b0, 32'h0080_0000, 1'b1}, // R4
        '{8'd5,  2'b01, 8'd32,  32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1}, // R5
        '{8'd6,  2'b01, 8'd63,  32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0}, // R6
        '{8'd4,  2'b10, 8'd4,   32'h8000_0010, 1'b1, 32'hF800_0001, 1'b0}, // R4
        '{8'd4,  2'b10, 8'd31,  32'h7FFF_FFFF, 1'b0, 32'h0000_0000, 1'b1}, // R4
        '{8'd7,  2'b10, 8'd32,  32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R7
        '{8'd7,  2'b10, 8'd50,  32'h7000_0000, 1'b1, 32'h0000_0000, 1'b0}, // R7
        '{8'd7,  2'b10, 8'd36,  32'hFFFF_0000, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R7
        '{8'd2,  2'b10, 8'd0,   32'hC000_0000, 1'b1, 32'hC000_0000, 1'b1}, // R2
        '{8'd1,  2'b00, 8'd68,  32'h0000_000F, 1'b1, 32'h0000_00F0, 1'b0}, // R1
        '{8'd1,  2'b01, 8'd96,  32'h0000_0001, 1'b1, 32'h0000_0000, 1'b0}, // R1 R5
        '{8'd11, 2'b11, 8'd4,   32'h8000_0000, 1'b1, 32'hF800_0000, 1'b0}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  kind_i = 2'b00;
    logic [7:0]  count_i = '0;
    logic [31:0] data_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o, flag_x_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_flag_unit #(.DATA_W(32), .CNT_W(8)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_i),
        .kind_i   (kind_i),
        .count_i  (count_i),
        .data_i   (data_i),
        .carry_i  (carry_i),
        .result_o (result_o),
        .flag_n_o (flag_n_o),
        .flag_z_o (flag_z_o),
        .flag_v_o (flag_v_o),
        .flag_c_o (flag_c_o),
        .flag_x_o (flag_x_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] flag_vec();
        return {flag_n_o, flag_z_o, flag_v_o, flag_c_o, flag_x_o};
    endfunction

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(flag_vec() == 5'b0, "R10", "flags after reset", 32'(flag_vec()), 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            logic [4:0] exp_f;
            tag = $sformatf("R%0d entry %0d", VECS[i].req, i);
            kind_i  = VECS[i].kind;
            count_i = VECS[i].cnt;
            data_i  = VECS[i].data;
            carry_i = VECS[i].cin;
            valid_i = 1'b1;
            #1;
            check(result_o == VECS[i].res, tag, "result", result_o, VECS[i].res);
            @(negedge clk);
            // R8 R9: X copies C, N/Z from result, V clear
            exp_f = {VECS[i].res[31], (VECS[i].res == 32'h0), 1'b0, VECS[i].c, VECS[i].c};
            check(flag_c_o == VECS[i].c, tag, "carry", 32'(flag_c_o), 32'(VECS[i].c));
            check(flag_vec() == exp_f, {tag, " R8 R9"}, "nzvcx", 32'(flag_vec()), 32'(exp_f));
            valid_i = 1'b0;
        end

        // R10: strobe low, inputs that would change every flag
        held = flag_vec();
        kind_i = 2'b00; count_i = 8'd0; data_i = 32'h0; carry_i = ~flag_c_o;
        repeat (3) @(negedge clk);
        check(flag_vec() == held, "R10", "flags hold with strobe low", 32'(flag_vec()), 32'(held));
        // R2 at the result port, same stimulus
        check(result_o == 32'h0, "R2", "zero-count pass-through", result_o, 32'h0);

        // R10: strobe high with the same inputs updates Z and C
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        check(flag_vec() == {1'b0, 1'b1, 1'b0, ~held[1], ~held[1]}, "R10",
              "flags load on strobe", 32'(flag_vec()), 32'({1'b0, 1'b1, 1'b0, ~held[1], ~held[1]}));

        // R10: reset mid-run clears the flags
        rst_n = 1'b0;
        #1;
        check(flag_vec() == 5'b0, "R10", "flags cleared by reset", 32'(flag_vec()), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(flag_vec() == 5'b0, "R10", "flags stay clear after reset", 32'(flag_vec()), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule